// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned N-bit operands and presents the full 2N-bit product with no clock, no registers and no control. Inside, a grid of unit cells each forms one partial-product bit with an AND gate and sums it in a full adder. A cell's carry does not move sideways to its neighbour in the same row. It drops diagonally into the next-higher column of the row below, so every row settles in one adder delay whatever its width.

The bottom row's sum and carry vectors are then merged by a single ripple-carry adder. That adder produces the upper N product bits, and each row of the grid gives one of the lower N bits as it leaves. The worst-case path is therefore about 2N adder delays, where an array whose rows each ripple their carries needs about 3N-2. The operand width N is a parameter with a default of 8. The product is only correct for nonnegative operands.

Top module: `csa_multiplier`

## Requirements
- R1: For every pair of unsigned N-bit operands, `product` equals `opA * opB` taken as a 2N-bit unsigned value.
- R2: Product bit 0 always equals `opA[0] & opB[0]`.
- R3: When either operand is zero, all 2N product bits are zero.
- R4: When one operand equals 1, the product equals the other operand zero-extended to 2N bits.
- R5: With both operands all ones, the product is (2^N-1)^2; for N=8 that is 16'hFE01, and for N=4 it is 8'hE1.
- R6: The product never exceeds (2^N-1)^2, so the merge row never produces a carry out of the top bit.
- R7: The block is purely combinational: the product follows an operand change within half a bench clock period, with no clock edge involved.
- R8: The structure is correct at any width N >= 2; both N=4 (all 256 operand pairs) and N=8 are built from the same source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | N | Multiplicand, unsigned |
| opB | input | N | Multiplier, unsigned |
| product | output | 2N | Unsigned product opA*opB |

## Verification
The bound checker compares the product on every settled evaluation against the arithmetic product. It also checks the LSB rule, zero absorption, the identity case and the upper bound, for whatever operands reach the block. What the checker cannot show is that the diagonal carry routing is right for every operand pair at a given width, or that a second width works too. The bench shows this by sweeping all 256 operand pairs at N=4, while random pairs and the extreme values run through an N=8 instance. It samples half a period after each change, which shows that no clock is involved.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;

  typedef struct packed {
    logic sum;
    logic carry;
  } addOut_t;

  function automatic addOut_t fullAdd(input logic x, input logic y, input logic z);
    addOut_t res;
    res.sum   = x ^ y ^ z;
    res.carry = (x & y) | (z & (x ^ y));
    return res;
  endfunction

endpackage

// File: rtl/csa_pp_grid.sv
// Partial-product plane: bit (row*N + col) is opA[col] & opB[row], weight row+col.
module csa_pp_grid #(
  parameter int N = 8
) (
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  output logic [N*N-1:0] ppFlat
);

  for (genvar row = 0; row < N; row++) begin : g_row
    for (genvar col = 0; col < N; col++) begin : g_col
      assign ppFlat[row*N + col] = opA[col] & opB[row];
    end
  end

endmodule

// File: rtl/csa_cell.sv
// One adder of the grid: adds the local partial-product bit to the sum and
// carry arriving from the row above.
module csa_cell
  import csa_mul_pkg::*;
(
  input  logic ppBit,
  input  logic sumIn,
  input  logic carryIn,
  output logic sumOut,
  output logic carryOut
);

  addOut_t res;

  assign res      = fullAdd(ppBit, sumIn, carryIn);
  assign sumOut   = res.sum;
  assign carryOut = res.carry;

endmodule

// File: rtl/csa_save_array.sv
// Carry-save rows. In row r, sum bit c has weight r+c and carry bit c has
// weight r+c+1, so a carry lands in the next-higher column of the next row.
module csa_save_array #(
  parameter int N = 8
) (
  input  logic [N*N-1:0] ppFlat,
  output logic [N-1:0]   lowBits,
  output logic [N-2:0]   restSum,
  output logic [N-1:0]   restCarry
);

  localparam int Cells = N * N;

  logic [Cells-1:0] sumFlat;
  logic [Cells-1:0] carryFlat;

  // Top row has no adders: its AND outputs pass through and carries start at zero.
  for (genvar col = 0; col < N; col++) begin : g_top
    assign sumFlat[col]   = ppFlat[col];
    assign carryFlat[col] = 1'b0;
  end

  for (genvar row = 1; row < N; row++) begin : g_row
    for (genvar col = 0; col < N; col++) begin : g_col
      logic sumIn;
      if (col + 1 < N) begin : g_inner
        assign sumIn = sumFlat[(row-1)*N + col + 1];
      end else begin : g_edge
        assign sumIn = 1'b0;
      end
      csa_cell u_cell (
        .ppBit   (ppFlat[row*N + col]),
        .sumIn   (sumIn),
        .carryIn (carryFlat[(row-1)*N + col]),
        .sumOut  (sumFlat[row*N + col]),
        .carryOut(carryFlat[row*N + col])
      );
    end
  end

  // Column 0 of each row is final: it gives one low product bit.
  for (genvar row = 0; row < N; row++) begin : g_low
    assign lowBits[row] = sumFlat[row*N];
  end

  for (genvar k = 0; k < N - 1; k++) begin : g_rest_sum
    assign restSum[k] = sumFlat[(N-1)*N + k + 1];
  end

  for (genvar k = 0; k < N; k++) begin : g_rest_carry
    assign restCarry[k] = carryFlat[(N-1)*N + k];
  end

endmodule

// File: rtl/csa_merge_adder.sv
// Ripple-carry merge of the last sum and carry vectors into the upper product half.
module csa_merge_adder
  import csa_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] opX,
  input  logic [N-1:0] opY,
  output logic [N-1:0] sum
);

  logic [N-1:0] chain;

  assign chain[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_bit
    addOut_t res;
    assign res    = fullAdd(opX[k], opY[k], chain[k]);
    assign sum[k] = res.sum;
    if (k < N - 1) begin : g_link
      assign chain[k+1] = res.carry;
    end
  end

endmodule

// File: rtl/csa_multiplier.sv
module csa_multiplier #(
  parameter int N = 8
) (
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  output logic [2*N-1:0] product
);

  localparam int PpBits = N * N;

  logic [PpBits-1:0] ppFlat;
  logic [N-1:0]      lowBits;
  logic [N-2:0]      restSum;
  logic [N-1:0]      restCarry;
  logic [N-1:0]      highBits;

  csa_pp_grid #(.N(N)) u_grid (
    .opA   (opA),
    .opB   (opB),
    .ppFlat(ppFlat)
  );

  csa_save_array #(.N(N)) u_array (
    .ppFlat   (ppFlat),
    .lowBits  (lowBits),
    .restSum  (restSum),
    .restCarry(restCarry)
  );

  csa_merge_adder #(.N(N)) u_merge (
    .opX({1'b0, restSum}),
    .opY(restCarry),
    .sum(highBits)
  );

  assign product = {highBits, lowBits};

endmodule

// File: rtl/csa_multiplier_checker.sv
module csa_multiplier_checker #(
  parameter int N = 8
) (
  input logic [N-1:0]   opA,
  input logic [N-1:0]   opB,
  input logic [2*N-1:0] product
);

  localparam logic [2*N-1:0] MaxA = {{N{1'b0}}, {N{1'b1}}};
  localparam logic [2*N-1:0] MaxP = MaxA * MaxA;

  logic [2*N-1:0] wideA;
  logic [2*N-1:0] wideB;

  assign wideA = {{N{1'b0}}, opA};
  assign wideB = {{N{1'b0}}, opB};

  always_comb begin
    a_r1_match: assert (product == wideA * wideB)
      else $error("R1 product %0h for %0h*%0h", product, opA, opB);
    a_r2_lsb: assert (product[0] == (opA[0] & opB[0]))
      else $error("R2 lsb mismatch");
    a_r3_zero: assert (!((opA == '0) || (opB == '0)) || product == '0)
      else $error("R3 nonzero product with zero operand");
    a_r4_identity: assert (!(wideB == 1) || product == wideA)
      else $error("R4 identity failed");
    a_r6_bound: assert (product <= MaxP)
      else $error("R6 product above bound");
  end

endmodule

bind csa_multiplier csa_multiplier_checker #(.N(N)) u_checker (
  .opA    (opA),
  .opB    (opB),
  .product(product)
);

// File: tb/test_csa_multiplier.sv
module test_csa_multiplier;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  a8, b8;
  logic [15:0] p8;
  logic [3:0]  a4, b4;
  logic [7:0]  p4;

  csa_multiplier #(.N(8)) i_csa_multiplier (.opA(a8), .opB(b8), .product(p8));
  csa_multiplier #(.N(4)) i_csa_multiplier_n4 (.opA(a4), .opB(b4), .product(p4));

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a8=%0h b8=%0h a4=%0h b4=%0h got=%0h exp=%0h", tag, a8, b8, a4, b4, got, exp);
    end
  endtask

  task automatic finishTest();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic drive(input logic [7:0] x8, input logic [7:0] y8,
                       input logic [3:0] x4, input logic [3:0] y4);
    @(posedge clk);
    a8 = x8; b8 = y8; a4 = x4; b4 = y4;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finishTest();
    end
  end

  initial begin
    a8 = '0; b8 = '0; a4 = '0; b4 = '0;
    @(negedge clk);
    check("R3 initial zero N8", p8, 16'h0000);
    check("R3 initial zero N4", {8'h00, p4}, 16'h0000);

    // R8/R1: every N=4 pair, random N=8 pairs alongside
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        logic [7:0] rx, ry;
        rx = 8'($urandom);
        ry = 8'($urandom);
        drive(rx, ry, 4'(x), 4'(y));
        check("R8 N4 exhaustive", {8'h00, p4}, 16'(x * y));
        check("R1 N8 random", p8, 16'(int'(rx) * int'(ry)));
        check("R2 lsb", {15'h0, p8[0]}, {15'h0, rx[0] & ry[0]});
        check("R6 bound", {15'h0, p8 > 16'hFE01}, 16'h0000);
      end
    end

    drive(8'h00, 8'hFF, 4'h0, 4'hF);
    check("R3 zero multiplicand N8", p8, 16'h0000);
    check("R3 zero multiplicand N4", {8'h00, p4}, 16'h0000);
    drive(8'hB7, 8'h00, 4'hA, 4'h0);
    check("R3 zero multiplier N8", p8, 16'h0000);
    drive(8'hC3, 8'h01, 4'h9, 4'h1);
    check("R4 one multiplier N8", p8, 16'h00C3);
    check("R4 one multiplier N4", {8'h00, p4}, 16'h0009);
    drive(8'h01, 8'h5A, 4'h1, 4'h6);
    check("R4 one multiplicand N8", p8, 16'h005A);
    drive(8'hFF, 8'hFF, 4'hF, 4'hF);
    check("R5 max N8", p8, 16'hFE01);
    check("R5 max N4", {8'h00, p4}, 16'h00E1);
    check("R6 max is bound", {15'h0, p8 > 16'hFE01}, 16'h0000);
    drive(8'h80, 8'h80, 4'h8, 4'h8);
    check("R1 top bits N8", p8, 16'h4000);
    drive(8'hAA, 8'h55, 4'h5, 4'hA);
    check("R1 alternating N8", p8, 16'h3872);

    // R7: change operands mid-cycle with no clock edge in between
    @(posedge clk);
    #1;
    a8 = 8'h0D; b8 = 8'h0B;
    #1;
    check("R7 no clock needed", p8, 16'h008F);
    a8 = 8'hFF; b8 = 8'h02;
    #0.5;
    check("R7 follows change", p8, 16'h01FE);

    finishTest();
  end

endmodule